// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point numbers (1 sign bit, 8-bit exponent biased by 127, 23-bit fraction with an implied leading 1 for normal values). A caller presents both operands, a subtract select and a 2-bit rounding mode together with a valid strobe. Exactly three clock cycles later the rounded result appears with its own valid strobe, plus two flags that report an exponent overflow and an exponent underflow. A new operation may be presented on every cycle.

The operands are decoded for zero, infinity and NaN before any arithmetic. Denormal inputs are flushed to a zero of their own sign. The arithmetic path restores the hidden bit and orders the operands by magnitude. It shifts the smaller significand right into three extra bits (guard, round and a sticky bit that collects every 1 shifted past it), then adds or subtracts. The raw result is normalised in either direction, rounded in the selected mode and renormalised when rounding carries out of the significand.

Top module: `fp32_addsub`

## Requirements
- R1: While `rst_n` is low and until the first operation completes, `out_valid`, `sum`, `ovf_flag` and `unf_flag` are all 0.
- R2: An operation accepted with `in_valid` high at a clock edge produces `out_valid` high three edges later; operations may be issued back to back, and `out_valid` is low on every other cycle.
- R3: With `rnd_mode` = 00 (nearest) and finite normal operands, `sum` is the correctly rounded value of `op_a + op_b` when `op_sub` = 0 and of `op_a - op_b` when `op_sub` = 1.
- R4: `rnd_mode` = 01 rounds toward zero, 10 rounds toward +infinity and 11 rounds toward -infinity, each giving the correctly rounded result in that direction.
- R5: In mode 00, a result lying exactly halfway between two representable values is rounded to the one whose least significant fraction bit is 0.
- R6: If either operand is NaN (exponent 255, fraction non-zero), or the operation adds infinities of opposite effective sign, `sum` is 0x7FC00000 and both flags are 0.
- R7: If exactly one operand is infinite, or both are infinite with the same effective sign, `sum` is that infinity and both flags are 0.
- R8: If the rounded result's biased exponent exceeds 254, `sum` is infinity with the result's sign and `ovf_flag` is 1.
- R9: If the normalised result's biased exponent, before rounding, is below 1, `sum` is zero with the result's sign and `unf_flag` is 1.
- R10: An operand with exponent field 0 is treated as a zero of its own sign whatever its fraction; `sum` is never a denormal encoding.
- R11: An exact zero result is +0, except that it is -0 when both operands have negative effective sign, or when the effective signs differ and `rnd_mode` = 11; both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 subtracts `op_b` from `op_a`, 0 adds |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | `sum` and flags hold a result |
| sum | output | 32 | Rounded result |
| ovf_flag | output | 1 | Result exponent overflowed to infinity |
| unf_flag | output | 1 | Result exponent underflowed to zero |

## Verification
A bad alignment shift or a lost sticky bit shows up only as an off-by-one-ulp `sum` in a directed rounding mode or on a halfway case, so the stimulus is weighted toward operands with near-equal exponents and every mode, and each result is compared against an exact wide-integer model that rounds without any guard bits. A fault in the leading-zero count after cancellation appears as a wrong exponent or a spurious underflow on the result three cycles after the operation. A corrupted special-case decode or a valid bit dropped between stages is visible on the very next result that passes through, because every issued operation and every idle cycle has a known `out_valid` value.

// File: rtl/fp32_addsub.sv
`timescale 1ns/1ps
module fp32_addsub (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        op_sub,
  input  logic [1:0]  rnd_mode,
  output logic        out_valid,
  output logic [31:0] sum,
  output logic        ovf_flag,
  output logic        unf_flag
);
  localparam int EW = 8;
  localparam int FW = 23;
  localparam int MW = FW + 1;
  localparam int XW = MW + 3;
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic [1:0] RM_NEAR = 2'b00, RM_ZERO = 2'b01, RM_UP = 2'b10, RM_DOWN = 2'b11;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  // stage 1: decode, order, align
  logic [EW-1:0] ea, eb, el, es, dexp;
  logic [MW-1:0] ma, mb, ml, ms;
  logic sa, sb, sl, swap, a_nan, b_nan, a_inf, b_inf;
  logic [4:0] dcl;
  logic [2*XW-1:0] wide;
  logic [XW-1:0] sal;

  assign ea = op_a[30:23];
  assign eb = op_b[30:23];
  assign sa = op_a[31];
  assign sb = op_b[31] ^ op_sub;
  assign ma = (ea == '0) ? '0 : {1'b1, op_a[FW-1:0]};
  assign mb = (eb == '0) ? '0 : {1'b1, op_b[FW-1:0]};
  assign a_nan = (ea == EMAX) && (op_a[FW-1:0] != '0);
  assign b_nan = (eb == EMAX) && (op_b[FW-1:0] != '0);
  assign a_inf = (ea == EMAX) && (op_a[FW-1:0] == '0);
  assign b_inf = (eb == EMAX) && (op_b[FW-1:0] == '0);
  assign swap = {eb, mb} > {ea, ma};
  assign el = swap ? eb : ea;
  assign es = swap ? ea : eb;
  assign ml = swap ? mb : ma;
  assign ms = swap ? ma : mb;
  assign sl = swap ? sb : sa;
  assign dexp = el - es;
  assign dcl = (dexp > 8'd27) ? 5'd27 : dexp[4:0];
  assign wide = {ms, 3'b000, {XW{1'b0}}} >> dcl;
  assign sal = {wide[2*XW-1:XW+1], wide[XW] | (|wide[XW-1:0])};

  logic s1_v, s1_sub, s1_sl, s1_nan, s1_inf, s1_isg, s1_zsg;
  logic [1:0] s1_rm;
  logic [EW-1:0] s1_el;
  logic [MW-1:0] s1_ml;
  logic [XW-1:0] s1_sal;

  always_ff @(posedge clk) begin
    if (!rst_n) s1_v <= 1'b0;
    else s1_v <= in_valid;
    s1_sub <= sa ^ sb;
    s1_sl  <= sl;
    s1_nan <= a_nan | b_nan | (a_inf & b_inf & (sa ^ sb));
    s1_inf <= a_inf | b_inf;
    s1_isg <= a_inf ? sa : sb;
    s1_zsg <= (sa & sb) | ((sa ^ sb) & (rnd_mode == RM_DOWN));
    s1_rm  <= rnd_mode;
    s1_el  <= el;
    s1_ml  <= ml;
    s1_sal <= sal;
  end

  // stage 2: add and normalise
  logic [XW:0] raw;
  logic [4:0] lz;
  logic found;
  logic [XW-1:0] nrm;
  logic signed [9:0] ne;

  assign raw = s1_sub ? ({1'b0, s1_ml, 3'b000} - {1'b0, s1_sal})
                      : ({1'b0, s1_ml, 3'b000} + {1'b0, s1_sal});

  always_comb begin
    lz = '0;
    found = 1'b0;
    for (int i = XW - 1; i >= 0; i--) begin
      if (!found) begin
        if (raw[i]) found = 1'b1;
        else lz = lz + 5'd1;
      end
    end
  end

  always_comb begin
    if (raw[XW]) begin
      nrm = {raw[XW:2], raw[1] | raw[0]};
      ne  = $signed({2'b00, s1_el}) + 10'sd1;
    end else begin
      nrm = raw[XW-1:0] << lz;
      ne  = $signed({2'b00, s1_el}) - $signed({5'b00000, lz});
    end
  end

  logic s2_v, s2_sl, s2_nan, s2_inf, s2_isg, s2_zsg, s2_zero;
  logic [1:0] s2_rm;
  logic [XW-1:0] s2_n;
  logic signed [9:0] s2_e;

  always_ff @(posedge clk) begin
    if (!rst_n) s2_v <= 1'b0;
    else s2_v <= s1_v;
    s2_sl   <= s1_sl;
    s2_nan  <= s1_nan;
    s2_inf  <= s1_inf;
    s2_isg  <= s1_isg;
    s2_zsg  <= s1_zsg;
    s2_zero <= (raw == '0);
    s2_rm   <= s1_rm;
    s2_n    <= nrm;
    s2_e    <= ne;
  end

  // stage 3: round, pack, flag
  logic g, r, st, lsb, inc;
  logic [MW:0] m25;
  logic [MW-1:0] mfin;
  logic signed [9:0] er;
  logic [31:0] res_c;
  logic ovf_c, unf_c;

  assign lsb = s2_n[3];
  assign g   = s2_n[2];
  assign r   = s2_n[1];
  assign st  = s2_n[0];

  always_comb begin
    case (s2_rm)
      RM_NEAR: inc = g & (r | st | lsb);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~s2_sl & (g | r | st);
      default: inc = s2_sl & (g | r | st);
    endcase
  end

  assign m25  = {1'b0, s2_n[XW-1:3]} + {{MW{1'b0}}, inc};
  assign mfin = m25[MW] ? m25[MW:1] : m25[MW-1:0];
  assign er   = s2_e + $signed({9'b0, m25[MW]});

  always_comb begin
    ovf_c = 1'b0;
    unf_c = 1'b0;
    if (s2_nan)                res_c = QNAN;
    else if (s2_inf)           res_c = {s2_isg, EMAX, {FW{1'b0}}};
    else if (s2_zero)          res_c = {s2_zsg, 31'b0};
    else if (s2_e < 10'sd1)  begin res_c = {s2_sl, 31'b0}; unf_c = 1'b1; end
    else if (er > 10'sd254)  begin res_c = {s2_sl, EMAX, {FW{1'b0}}}; ovf_c = 1'b1; end
    else                       res_c = {s2_sl, er[EW-1:0], mfin[FW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
      ovf_flag  <= 1'b0;
      unf_flag  <= 1'b0;
    end else begin
      out_valid <= s2_v;
      if (s2_v) begin
        sum      <= res_c;
        ovf_flag <= ovf_c;
        unf_flag <= unf_c;
      end else begin
        ovf_flag <= 1'b0;
        unf_flag <= 1'b0;
      end
    end
  end
endmodule

module fp32_addsub_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [31:0] sum,
  input logic        ovf_flag,
  input logic        unf_flag
);
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> ##3 out_valid); // R2
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sum[30:23] == 8'hFF && sum[22:0] != 23'd0) |-> sum == 32'h7FC0_0000); // R6
  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> (out_valid && sum[30:0] == 31'h7F80_0000 && !unf_flag)); // R8
  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |-> (out_valid && sum[30:0] == 31'd0)); // R9
  AST_NO_DENORM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(sum[30:23] == 8'd0 && sum[22:0] != 23'd0)); // R10
endmodule

bind fp32_addsub fp32_addsub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .sum(sum), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
);

// File: tb/tb_fp32_addsub.sv
`timescale 1ns/1ps
module tb_fp32_addsub;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, op_sub = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0] rnd_mode = '0;
  logic out_valid, ovf_flag, unf_flag;
  logic [31:0] sum;

  fp32_addsub dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .rnd_mode(rnd_mode), .out_valid(out_valid), .sum(sum),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic        ev [4];
  logic [33:0] eq [4];
  string       et [4];

  // exact reference: returns {ovf, unf, result}
  function automatic logic [33:0] ref_add(input logic [31:0] a, b, input logic s, input logic [1:0] rm);
    logic sa, sb, rs, half, below, inc, hit;
    logic [7:0] ea, eb;
    logic [23:0] ma, mb;
    logic [299:0] A, B, M;
    logic [24:0] k;
    int emin, p, E;
    sa = a[31]; sb = b[31] ^ s; ea = a[30:23]; eb = b[30:23];
    if ((ea == 8'hFF && a[22:0] != 0) || (eb == 8'hFF && b[22:0] != 0)) return {2'b00, 32'h7FC00000};
    if (ea == 8'hFF && eb == 8'hFF) return (sa != sb) ? {2'b00, 32'h7FC00000} : {2'b00, sa, 8'hFF, 23'd0};
    if (ea == 8'hFF) return {2'b00, sa, 8'hFF, 23'd0};
    if (eb == 8'hFF) return {2'b00, sb, 8'hFF, 23'd0};
    ma = (ea == 0) ? 24'd0 : {1'b1, a[22:0]};
    mb = (eb == 0) ? 24'd0 : {1'b1, b[22:0]};
    emin = (ea < eb) ? int'(ea) : int'(eb);
    A = 300'(ma) << (int'(ea) - emin);
    B = 300'(mb) << (int'(eb) - emin);
    if (sa == sb) begin M = A + B; rs = sa; end
    else if (A >= B) begin M = A - B; rs = sa; end
    else begin M = B - A; rs = sb; end
    if (M == 0) return {2'b00, (sa == sb) ? sa : (rm == 2'b11), 31'd0};
    p = 0; hit = 0;
    for (int i = 299; i >= 0; i--) if (!hit && M[i]) begin p = i; hit = 1; end
    E = p + emin - 23;
    if (E < 1) return {2'b01, rs, 31'd0};
    if (p >= 23) begin
      k = 25'(M >> (p - 23));
      half = (p >= 24) ? M[p-24] : 1'b0;
      below = (p >= 25) ? |(M & ((300'd1 << (p - 24)) - 300'd1)) : 1'b0;
    end else begin
      k = 25'(M << (23 - p)); half = 0; below = 0;
    end
    case (rm)
      2'b00: inc = half & (below | k[0]);
      2'b01: inc = 0;
      2'b10: inc = !rs & (half | below);
      default: inc = rs & (half | below);
    endcase
    k = k + 25'(inc);
    if (k[24]) begin k = k >> 1; E++; end
    if (E > 254) return {2'b10, rs, 8'hFF, 23'd0};
    return {2'b00, rs, 8'(E), k[22:0]};
  endfunction

  task automatic chk(input logic [33:0] got, exp, input string t);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", t, got, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [31:0] x, y, input logic s, input logic [1:0] m, input string t);
    int ci;
    logic [33:0] r;
    string tg;
    @(negedge clk);
    ci = (cyc + 1) % 4;
    chk({33'd0, out_valid}, {33'd0, ev[ci]}, "R2 out_valid");
    if (ev[ci] && out_valid) chk({ovf_flag, unf_flag, sum}, eq[ci], et[ci]);
    r = ref_add(x, y, s, m);
    tg = t;
    if (tg == "") tg = r[33] ? "R8" : r[32] ? "R9" : (r[31:0] == 32'h7FC00000) ? "R6" : (m != 0) ? "R4" : "R3";
    ev[cyc % 4] = v; eq[cyc % 4] = r; et[cyc % 4] = tg;
    in_valid = v; op_a = x; op_b = y; op_sub = s; rnd_mode = m;
    cyc++;
  endtask

  function automatic logic [31:0] rnd_op(input logic [7:0] near, input bit use_near);
    int k, e;
    k = $urandom % 100;
    if (k < 3) return {1'($urandom), 31'd0};
    if (k < 5) return {1'($urandom), 8'd0, 23'($urandom)};
    if (k < 7) return {1'($urandom), 8'hFF, 23'd0};
    if (k < 9) return {1'($urandom), 8'hFF, 23'($urandom) | 23'd1};
    if (use_near) begin
      e = int'(near) + int'($urandom % 7) - 3;
      if (e < 1) e = 1;
      if (e > 254) e = 254;
    end else e = 1 + int'($urandom % 254);
    return {1'($urandom), 8'(e), 23'($urandom)};
  endfunction

  initial begin
    logic [31:0] x, y;
    for (int i = 0; i < 4; i++) begin ev[i] = 0; eq[i] = '0; et[i] = ""; end
    void'($urandom(32'd20240917));
    repeat (3) begin
      @(negedge clk);
      chk({out_valid, ovf_flag, unf_flag, sum}, 34'd0, "R1 reset state");
    end
    rst_n = 1'b1;
    // directed corners
    cycle(1, 32'h3F800000, 32'h33800000, 0, 2'b00, "R5 tie to even down");
    cycle(1, 32'h3F800001, 32'h33800000, 0, 2'b00, "R5 tie to even up");
    cycle(1, 32'h3F800000, 32'h33800000, 0, 2'b10, "R4 up");
    cycle(1, 32'hBF800000, 32'h33800000, 1, 2'b11, "R4 down");
    cycle(1, 32'h7F7FFFFF, 32'h7F7FFFFF, 0, 2'b00, "R8 overflow");
    cycle(1, 32'h7F7FFFFF, 32'h73000000, 0, 2'b00, "R8 rounding overflow");
    cycle(1, 32'h00800001, 32'h00800000, 1, 2'b00, "R9 underflow");
    cycle(1, 32'h00000001, 32'h3F800000, 0, 2'b00, "R10 denormal in");
    cycle(1, 32'h80000005, 32'h80000003, 0, 2'b00, "R10 denormals as zero");
    cycle(1, 32'h3F800000, 32'h3F800000, 1, 2'b00, "R11 cancel");
    cycle(1, 32'h3F800000, 32'h3F800000, 1, 2'b11, "R11 cancel down");
    cycle(1, 32'h80000000, 32'h80000000, 0, 2'b00, "R11 neg zeros");
    cycle(1, 32'h7F800000, 32'h7F800000, 1, 2'b00, "R6 inf minus inf");
    cycle(1, 32'h7FA00000, 32'h00000001, 0, 2'b01, "R6 nan in");
    cycle(1, 32'hFF800000, 32'h3F800000, 0, 2'b00, "R7 inf plus finite");
    cycle(1, 32'h7F800000, 32'h7F800000, 0, 2'b10, "R7 same infs");
    cycle(0, 0, 0, 0, 2'b00, "");
    cycle(1, 32'h40A00000, 32'h3F000000, 1, 2'b00, "R3 sub");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      x = rnd_op(8'd0, 0);
      y = rnd_op(x[30:23], ($urandom % 2) == 0);
      cycle(($urandom % 8) != 0, x, y, 1'($urandom), 2'($urandom), "");
    end
    repeat (4) cycle(0, 0, 0, 0, 2'b00, "");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog got running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule